// File: doc/BRIEF.md
# Dual-Clock Operating Mode Controller

This block holds the operating mode of a small microcontroller that can run from two clock sources: a fast gear clock and a slow low-frequency clock. The slow clock is used divided by four. The block tracks four modes: normal, slow with the fast oscillator still running, slow with the fast oscillator stopped, and idle. Software control bits and two events move it between these modes: an idle request and a wakeup. It does not follow these inputs blindly. A move is taken only along a fixed graph, and only when the oscillator the next mode depends on is ready.

Everything runs in one reference clock domain. The two clock sources arrive as single-cycle tick enables. The outputs are levels and strobes that gate downstream logic:
- the system clock source select,
- the fast oscillator enable,
- the CPU and watchdog clock enables,
- the run enables for the prescaler and for divider stages 1 to 8,
- a machine-cycle strobe that pulses once per machine cycle in every mode.

After reset the block is in normal mode, which is single-clock operation. The slow modes stay closed until software has enabled the low-frequency oscillator and that oscillator reports that it is stable.

Top module: `dual_clk_mode_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, the outputs are: mode_o = 0 (normal), sys_clk_sel_o = 0, fast_osc_en_o = 1, cpu_clk_en_o = 1, wdt_clk_en_o = 1, presc_run_o = 1 and div_low_run_o = 1.
- R2: In normal mode with sys_sel_slow_i = 1, slow_osc_en_i = 1, slow_osc_stable_i = 1 and idle_req_i = 0, mode_o becomes 1 (slow, fast oscillator running) after the next clock edge.
- R3: In normal mode, a slow request is ignored while slow_osc_en_i or slow_osc_stable_i is 0, and mode_o stays 0.
- R4: In mode 1, fast_osc_keep_i = 0 moves to mode 2 (slow, fast oscillator stopped). In mode 2, fast_osc_keep_i = 1 moves back to mode 1. fast_osc_en_o is 0 only in mode 2. Mode 2 is reachable only from mode 1.
- R5: In normal mode, fast_osc_keep_i = 0 is rejected: mode_o stays 0 and fast_osc_en_o stays 1.
- R6: Mode 1 returns to mode 0 only when sys_sel_slow_i = 0 and fast_osc_rdy_i = 1 at the same clock edge. Otherwise it waits in mode 1.
- R7: In modes 1 and 2: sys_clk_sel_o = 1, presc_run_o = 0 and div_low_run_o = 0. In modes 0 and 3: sys_clk_sel_o = 0 and both run enables are 1.
- R8: In normal mode, idle_req_i = 1 enters mode 3 (idle) after the next edge, and it takes priority over a slow request. In mode 3: cpu_clk_en_o = 0, wdt_clk_en_o = 0, and the prescaler keeps running. idle_req_i has no effect in modes 1 and 2.
- R9: In mode 3, wake_i = 1 always returns the block to mode 0, even if a slow request is pending. Without wake_i the block stays in mode 3.
- R10: mode_o encodes the mode as 0 = normal, 1 = slow with fast oscillator running, 2 = slow with fast oscillator stopped, 3 = idle.
- R11: mcyc_stb_o is combinational in the current cycle:
  - In modes 0 and 3 it equals fast_tick_i.
  - In modes 1 and 2 it ignores fast_tick_i and pulses together with every fourth slow_tick_i. The slow ticks are counted from reset and the count runs in every mode, so the pulses fall on the 4th, 8th, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fast_tick_i | input | 1 | One-cycle enable per gear clock period |
| slow_tick_i | input | 1 | One-cycle enable per low-frequency clock period |
| sys_sel_slow_i | input | 1 | Control bit: select the slow system clock |
| fast_osc_keep_i | input | 1 | Control bit: keep the fast oscillator running |
| slow_osc_en_i | input | 1 | Control bit: low-frequency oscillator enabled |
| slow_osc_stable_i | input | 1 | Low-frequency oscillator is stable |
| fast_osc_rdy_i | input | 1 | Fast oscillator has finished warm-up |
| idle_req_i | input | 1 | Request to enter idle |
| wake_i | input | 1 | Idle release event |
| mode_o | output | 2 | Current mode code |
| sys_clk_sel_o | output | 1 | 0 = gear clock, 1 = slow clock divided by four |
| fast_osc_en_o | output | 1 | Fast oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| wdt_clk_en_o | output | 1 | Watchdog clock gate enable |
| presc_run_o | output | 1 | Prescaler output enable |
| div_low_run_o | output | 1 | Divider stages 1 to 8 output enable |
| mcyc_stb_o | output | 1 | Machine-cycle strobe |

## Verification
Every gate output is decoded straight from the registered mode. A wrong state therefore shows at mode_o and on the clock-select and run enables in the cycle after the faulty edge. No deferred status hides it. The vector walk samples all of these outputs after each edge. It steps through the rejected requests, so that a transition which should not have been taken shows up at once. A miscount in the divide-by-four counter shows only through the position of the strobe pulses. The bench therefore counts slow ticks from reset and checks the strobe on each one.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_SLOW2  = 2'd1,
    MODE_SLOW1  = 2'd2,
    MODE_IDLE2  = 2'd3
  } mode_e;
endpackage

// File: rtl/dcm_mode_fsm.sv
module dcm_mode_fsm
  import dcm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sel_slow_i,
  input  logic  fast_keep_i,
  input  logic  slow_ok_i,
  input  logic  fast_rdy_i,
  input  logic  idle_req_i,
  input  logic  wake_i,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_NORMAL: begin
        if (idle_req_i)                   mode_d = MODE_IDLE2;
        else if (sel_slow_i && slow_ok_i) mode_d = MODE_SLOW2;
      end
      MODE_SLOW2: begin
        // oscillator stop wins over a return to normal
        if (!fast_keep_i)                    mode_d = MODE_SLOW1;
        else if (!sel_slow_i && fast_rdy_i) mode_d = MODE_NORMAL;
      end
      MODE_SLOW1: if (fast_keep_i) mode_d = MODE_SLOW2;
      MODE_IDLE2: if (wake_i)      mode_d = MODE_NORMAL;
      default:                     mode_d = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) mode_q <= MODE_NORMAL;
    else         mode_q <= mode_d;

  assign mode_o = mode_q;
endmodule

// File: rtl/dcm_tick_div.sv
module dcm_tick_div #(
  parameter int unsigned DIV = 4,
  localparam int unsigned W  = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic wrap_o
);
  localparam logic [W-1:0] LAST = W'(DIV - 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

  assign wrap_o = tick_i && (cnt_q == LAST);
endmodule

// File: rtl/dcm_gate_decode.sv
module dcm_gate_decode
  import dcm_pkg::*;
(
  input  mode_e mode_i,
  input  logic  fast_tick_i,
  input  logic  slow_wrap_i,
  output logic  sys_clk_sel_o,
  output logic  fast_osc_en_o,
  output logic  cpu_clk_en_o,
  output logic  wdt_clk_en_o,
  output logic  presc_run_o,
  output logic  div_low_run_o,
  output logic  mcyc_stb_o
);
  logic slow_mode;
  assign slow_mode     = (mode_i == MODE_SLOW2) || (mode_i == MODE_SLOW1);
  assign sys_clk_sel_o = slow_mode;
  assign fast_osc_en_o = (mode_i != MODE_SLOW1);
  assign cpu_clk_en_o  = (mode_i != MODE_IDLE2);
  assign wdt_clk_en_o  = (mode_i != MODE_IDLE2);
  assign presc_run_o   = !slow_mode;
  assign div_low_run_o = !slow_mode;
  assign mcyc_stb_o    = slow_mode ? slow_wrap_i : fast_tick_i;
endmodule

// File: rtl/dual_clk_mode_ctrl.sv
module dual_clk_mode_ctrl
  import dcm_pkg::*;
#(
  parameter int unsigned SLOW_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fast_tick_i,
  input  logic       slow_tick_i,
  input  logic       sys_sel_slow_i,
  input  logic       fast_osc_keep_i,
  input  logic       slow_osc_en_i,
  input  logic       slow_osc_stable_i,
  input  logic       fast_osc_rdy_i,
  input  logic       idle_req_i,
  input  logic       wake_i,
  output logic [1:0] mode_o,
  output logic       sys_clk_sel_o,
  output logic       fast_osc_en_o,
  output logic       cpu_clk_en_o,
  output logic       wdt_clk_en_o,
  output logic       presc_run_o,
  output logic       div_low_run_o,
  output logic       mcyc_stb_o
);
  mode_e mode;
  logic  slow_wrap;

  dcm_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_slow_i  (sys_sel_slow_i),
    .fast_keep_i (fast_osc_keep_i),
    .slow_ok_i   (slow_osc_en_i && slow_osc_stable_i),
    .fast_rdy_i  (fast_osc_rdy_i),
    .idle_req_i  (idle_req_i),
    .wake_i      (wake_i),
    .mode_o      (mode)
  );

  dcm_tick_div #(.DIV(SLOW_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (slow_tick_i),
    .wrap_o (slow_wrap)
  );

  dcm_gate_decode u_dec (
    .mode_i        (mode),
    .fast_tick_i   (fast_tick_i),
    .slow_wrap_i   (slow_wrap),
    .sys_clk_sel_o (sys_clk_sel_o),
    .fast_osc_en_o (fast_osc_en_o),
    .cpu_clk_en_o  (cpu_clk_en_o),
    .wdt_clk_en_o  (wdt_clk_en_o),
    .presc_run_o   (presc_run_o),
    .div_low_run_o (div_low_run_o),
    .mcyc_stb_o    (mcyc_stb_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/dual_clk_mode_chk.sv
module dual_clk_mode_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fast_tick_i,
  input logic       sys_sel_slow_i,
  input logic       slow_osc_en_i,
  input logic       slow_osc_stable_i,
  input logic       fast_osc_rdy_i,
  input logic [1:0] mode_o,
  input logic       fast_osc_en_o,
  input logic       cpu_clk_en_o,
  input logic       wdt_clk_en_o,
  input logic       presc_run_o,
  input logic       div_low_run_o,
  input logic       mcyc_stb_o
);
  // R2 R3
  slow_entry_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && $past(mode_o) == 2'd0) |-> $past(slow_osc_en_i && slow_osc_stable_i));

  // R4
  slow1_from_slow2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2) |-> ($past(mode_o) == 2'd1 || $past(mode_o) == 2'd2));

  // R4
  fast_osc_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fast_osc_en_o) |-> (mode_o == 2'd2));

  // R6
  slow_exit_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && $past(mode_o) == 2'd1) |-> $past(fast_osc_rdy_i && !sys_sel_slow_i));

  // R7
  slow_div_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 || mode_o == 2'd2) |-> (!presc_run_o && !div_low_run_o));

  // R8
  idle_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3) |-> (!cpu_clk_en_o && !wdt_clk_en_o && presc_run_o));

  // R9
  idle_exit_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 2'd3 && mode_o != 2'd3) |-> (mode_o == 2'd0));

  // R11
  fast_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 || mode_o == 2'd3) |-> (mcyc_stb_o == fast_tick_i));
endmodule

bind dual_clk_mode_ctrl dual_clk_mode_chk u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .fast_tick_i       (fast_tick_i),
  .sys_sel_slow_i    (sys_sel_slow_i),
  .slow_osc_en_i     (slow_osc_en_i),
  .slow_osc_stable_i (slow_osc_stable_i),
  .fast_osc_rdy_i    (fast_osc_rdy_i),
  .mode_o            (mode_o),
  .fast_osc_en_o     (fast_osc_en_o),
  .cpu_clk_en_o      (cpu_clk_en_o),
  .wdt_clk_en_o      (wdt_clk_en_o),
  .presc_run_o       (presc_run_o),
  .div_low_run_o     (div_low_run_o),
  .mcyc_stb_o        (mcyc_stb_o)
);

// File: tb/dual_clk_mode_ctrl_bench.sv
module dual_clk_mode_ctrl_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fast_tick, slow_tick, sel, keep, sen, sst, rdy, idle, wake;
  logic [1:0] mode;
  logic sys_sel, fen, cpu_en, wdt_en, presc, divl, stb;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_clk_mode_ctrl u_dual_clk_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .fast_tick_i(fast_tick), .slow_tick_i(slow_tick),
    .sys_sel_slow_i(sel), .fast_osc_keep_i(keep), .slow_osc_en_i(sen),
    .slow_osc_stable_i(sst), .fast_osc_rdy_i(rdy), .idle_req_i(idle), .wake_i(wake),
    .mode_o(mode), .sys_clk_sel_o(sys_sel), .fast_osc_en_o(fen), .cpu_clk_en_o(cpu_en),
    .wdt_clk_en_o(wdt_en), .presc_run_o(presc), .div_low_run_o(divl), .mcyc_stb_o(stb)
  );

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected gate outputs per mode, from R4 R7 R8
  task automatic check_gates(input logic [1:0] m, input string tag);
    logic slow_m;
    slow_m = (m == 2'd1) || (m == 2'd2);
    check(mode, m, {tag, " R10 mode"});
    check({1'b0, sys_sel}, {1'b0, slow_m}, {tag, " R7 sys_sel"});
    check({presc, divl}, {!slow_m, !slow_m}, {tag, " R7 run"});
    check({1'b0, fen}, {1'b0, m != 2'd2}, {tag, " R4 fast_osc_en"});
    check({cpu_en, wdt_en}, {m != 2'd3, m != 2'd3}, {tag, " R8 cpu/wdt"});
  endtask

  // {sel, keep, sen, sst, rdy, idle, wake, exp_mode[1:0]}
  localparam int NV = 16;
  localparam logic [8:0] VEC [NV] = '{
    9'b1_1_0_1_0_0_0_00, // R3 osc disabled
    9'b1_1_1_0_0_0_0_00, // R3 not stable
    9'b0_0_1_1_0_0_0_00, // R5 keep clear rejected
    9'b1_1_1_1_0_0_0_01, // R2
    9'b1_1_1_1_1_1_0_01, // R8 idle ignored in slow
    9'b1_0_1_1_0_0_0_10, // R4 to slow1
    9'b0_0_1_1_1_0_0_10, // R4 stays slow1
    9'b0_1_1_1_0_0_0_01, // R4 back to slow2
    9'b0_1_1_1_0_0_0_01, // R6 waits for ready
    9'b0_1_1_1_1_0_0_00, // R6 to normal
    9'b0_1_1_1_0_1_0_11, // R8 idle
    9'b1_1_1_1_0_0_0_11, // R9 stays without wake
    9'b0_1_1_1_0_0_1_00, // R9 wake
    9'b1_1_1_1_0_1_0_11, // R8 idle wins over slow
    9'b1_1_1_1_0_0_1_00, // R9 wake returns to normal
    9'b1_1_1_1_0_0_0_01  // R2
  };

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    fast_tick = 0; slow_tick = 0; sel = 0; keep = 1; sen = 0; sst = 0;
    rdy = 0; idle = 0; wake = 0;
    #3;
    check_gates(2'd0, "R1 in reset");
    step(); step();
    rst_ni = 1'b1;
    step();
    check_gates(2'd0, "R1 after reset");

    for (int i = 0; i < NV; i++) begin
      {sel, keep, sen, sst, rdy, idle, wake} = VEC[i][8:2];
      step();
      check_gates(VEC[i][1:0], $sformatf("vec%0d", i));
    end
    idle = 0; wake = 0; sel = 1; keep = 1; rdy = 0;

    // R11 slow mode strobe on every fourth slow tick, fast ticks ignored
    for (int k = 1; k <= 8; k++) begin
      slow_tick = 1; fast_tick = 1;
      #1 check({1'b0, stb}, {1'b0, (k % 4) == 0}, $sformatf("R11 slow tick %0d", k));
      step();
      slow_tick = 0; fast_tick = 0;
      step();
    end
    // back to normal: R6 then R11 fast pass-through
    sel = 0; rdy = 1;
    step();
    check(mode, 2'd0, "R6 return");
    fast_tick = 1;
    #1 check({1'b0, stb}, 2'd1, "R11 normal fast tick");
    fast_tick = 0; slow_tick = 1;
    #1 check({1'b0, stb}, 2'd0, "R11 normal slow tick ignored");
    step();
    slow_tick = 0; idle = 1;
    step();
    idle = 0;
    check(mode, 2'd3, "R8 idle");
    fast_tick = 1;
    #1 check({1'b0, stb}, 2'd1, "R11 idle fast tick");
    fast_tick = 0;
    step();
    // R1 reset from idle
    rst_ni = 0;
    #1 check_gates(2'd0, "R1 reset from idle");
    step();
    rst_ni = 1;
    step();
    check_gates(2'd0, "R1 released");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule